// File: doc/BRIEF.md
# I2C Bit-Level SCL Timing Generator

This block produces the SCL waveform for an I2C master, and the instants at which SDA may change and is sampled. A byte-level sequencer above it issues one bus action at a time: a START, a STOP, a repeated START, the transmission of one bit, or the reception of one bit. The generator carries the action out and pulses `done` when it ends. For a receive action it also returns the sampled SDA value. Both bus lines are open-drain. Each one is modelled as an output enable, where 1 pulls the line low, plus a readback input of the real line level.

Four cycle counts, all in system clocks, set the timing. The bit period is the system clock rate divided by the bus rate. The bus rate defaults to 100 kHz and must not exceed 400 kHz. The SCL low time, the setup time for a START/STOP condition and the data setup time are separate inputs. Their usual settings are half, half and one sixteenth of the bit period. A slave that holds SCL low after the master releases it stretches the high phase: the generator waits and reports that it is waiting.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `scl_oe`, `sda_oe` and `done` are low.
- R2: A START request (code 0) taken while idle pulls SDA low with SCL released. SCL is pulled low `cfg_cond_setup` cycles after acceptance, in the same cycle that `done` pulses.
- R3: A transmit (code 3) or receive (code 4) request pulls SCL low for `cfg_low` cycles and then releases it for `cfg_period - cfg_low` high cycles. `done` pulses `cfg_period` cycles after acceptance when no stretching occurs, and SCL is pulled low again at that moment.
- R4: On a transmit, `sda_oe` takes the inverse of `req_bit`, so 1 releases the line. On a receive, SDA is released. Any change of `sda_oe` lands exactly `cfg_data_setup` cycles before SCL is released, and never in the same cycle as the release (1 <= `cfg_data_setup` < `cfg_low`).
- R5: On a receive, `rx_bit` takes the SDA level seen in high-phase cycle floor((`cfg_period - cfg_low`)/2), counting from 0.
- R6: A STOP request (code 1) drives SDA low during a `cfg_low` low phase, releases SCL for `cfg_cond_setup` cycles, then releases SDA. `done` pulses `cfg_low + cfg_cond_setup` cycles after acceptance, and both lines are left released.
- R7: A repeated START request (code 2) releases SDA during a `cfg_low` low phase and releases SCL for `cfg_cond_setup` cycles. It then pulls SDA low for `cfg_cond_setup` cycles and pulls SCL low. `done` pulses `cfg_low + 2*cfg_cond_setup` cycles after acceptance.
- R8: While SCL is released but reads back low, the high-phase count holds and `stretch` is high. Each stretched cycle adds exactly one cycle to the action, and `done` never pulses in the cycle after a stretched cycle.
- R9: Requests that arrive while an action is in progress are ignored, and so are codes 5 to 7 when idle. Neither produces a `done` nor changes the line enables.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CNT_W | Bit period in system clocks |
| cfg_low | input | CNT_W | SCL low time in system clocks |
| cfg_cond_setup | input | CNT_W | START/STOP setup and hold time in system clocks |
| cfg_data_setup | input | CNT_W | SDA setup before SCL release, in system clocks |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_cmd | input | 3 | 0 START, 1 STOP, 2 repeated START, 3 transmit, 4 receive |
| req_bit | input | 1 | Bit value for a transmit |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_bit | output | 1 | Last received bit |
| done | output | 1 | One-cycle pulse when an action ends |
| stretch | output | 1 | High while a slave holds SCL low in a high phase |

## Verification
A wrong phase or count value shows up as a `done` pulse that comes too early or too late. The error appears within the same action, so every action's latency is compared against its cycle total. A misplaced data change or sample point leaves `done` on time. It shows instead as a wrong gap between the SDA change and the SCL release, or as a wrong `rx_bit` when the slave flips SDA right after the midpoint. A broken stall shows as a `stretch` count that differs from the number of cycles the slave held SCL, or as a latency that does not grow by that number.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

    typedef enum logic [2:0] {
        CMD_START  = 3'd0,
        CMD_STOP   = 3'd1,
        CMD_RSTART = 3'd2,
        CMD_WRITE  = 3'd3,
        CMD_READ   = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        cmd_e cmd;
        logic bit_val;
    } op_t;

    localparam int unsigned BUS_HZ_DEFAULT = 100_000;
    localparam int unsigned BUS_HZ_MAX     = 400_000;

    // Bit period in system clocks; an out-of-range bus rate falls back to a legal one.
    function automatic int unsigned bit_cycles(input int unsigned sys_hz, input int unsigned bus_hz);
        int unsigned r;
        r = (bus_hz == 0) ? BUS_HZ_DEFAULT : ((bus_hz > BUS_HZ_MAX) ? BUS_HZ_MAX : bus_hz);
        return sys_hz / r;
    endfunction

    function automatic int unsigned low_cycles(input int unsigned period);
        return period / 2;
    endfunction

    function automatic int unsigned cond_cycles(input int unsigned period);
        return period / 2;
    endfunction

    function automatic int unsigned data_cycles(input int unsigned period);
        return period / 16;
    endfunction

    function automatic logic is_bit_cmd(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_READ);
    endfunction

endpackage

// File: rtl/i2c_tm_counter.sv
module i2c_tm_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else if (advance) count <= count + ONE;
    end

    assign last = (count == limit - ONE);
endmodule

// File: rtl/i2c_tm_sampler.sv
module i2c_tm_sampler (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic din,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else if (strobe) q <= din;
    end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_tm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_cond_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic             req_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             rx_bit,
    output logic             done,
    output logic             stretch
);
    localparam logic [2:0]       CMD_MAX = 3'(CMD_READ);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    phase_e           ph;
    op_t              op;
    logic             scl_oe_q, sda_oe_q, done_q;
    logic [CNT_W-1:0] high_len, limit, count, change_idx;
    logic             last, advance, clear, accept, sda_target, sample_strobe;

    assign accept   = (ph == PH_IDLE) && req_valid && (req_cmd <= CMD_MAX);
    assign high_len = is_bit_cmd(op.cmd) ? (cfg_period - cfg_low) : cfg_cond_setup;

    always_comb begin
        case (ph)
            PH_HIGH: limit = high_len;
            PH_HOLD: limit = cfg_cond_setup;
            default: limit = cfg_low;
        endcase
    end

    assign advance = (ph == PH_LOW) || (ph == PH_HOLD) || ((ph == PH_HIGH) && scl_in);
    assign clear   = (ph == PH_IDLE) || (last && advance);
    assign stretch = (ph == PH_HIGH) && !scl_in;

    // Cycle of the low phase in which SDA is updated, so it settles data_setup cycles before release.
    assign change_idx = (cfg_data_setup < cfg_low) ? (cfg_low - cfg_data_setup - ONE) : '0;

    always_comb begin
        case (op.cmd)
            CMD_WRITE: sda_target = ~op.bit_val;
            CMD_STOP:  sda_target = 1'b1;
            CMD_START: sda_target = 1'b1;
            default:   sda_target = 1'b0;
        endcase
    end

    assign sample_strobe = (ph == PH_HIGH) && scl_in && (op.cmd == CMD_READ)
                           && (count == (high_len >> 1));

    i2c_tm_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .advance (advance),
        .limit   (limit),
        .count   (count),
        .last    (last)
    );

    i2c_tm_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .strobe (sample_strobe),
        .din    (sda_in),
        .q      (rx_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            op       <= '{cmd: CMD_START, bit_val: 1'b0};
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        op <= '{cmd: cmd_e'(req_cmd), bit_val: req_bit};
                        if (cmd_e'(req_cmd) == CMD_START) begin
                            sda_oe_q <= 1'b1;
                            ph       <= PH_HOLD;
                        end else begin
                            scl_oe_q <= 1'b1;
                            ph       <= PH_LOW;
                        end
                    end
                end
                PH_LOW: begin
                    if (count == change_idx) sda_oe_q <= sda_target;
                    if (last) begin
                        scl_oe_q <= 1'b0;
                        ph       <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (scl_in && last) begin
                        case (op.cmd)
                            CMD_STOP: begin
                                sda_oe_q <= 1'b0;
                                done_q   <= 1'b1;
                                ph       <= PH_IDLE;
                            end
                            CMD_RSTART: begin
                                sda_oe_q <= 1'b1;
                                ph       <= PH_HOLD;
                            end
                            default: begin
                                scl_oe_q <= 1'b1;
                                done_q   <= 1'b1;
                                ph       <= PH_IDLE;
                            end
                        endcase
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        scl_oe_q <= 1'b1;
                        done_q   <= 1'b1;
                        ph       <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign scl_oe = scl_oe_q;
    assign sda_oe = sda_oe_q;
    assign done   = done_q;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic scl_oe,
    input logic sda_oe,
    input logic rx_bit,
    input logic done,
    input logic stretch
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!done && !scl_oe && !sda_oe));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R4
    sda_release_chk: assert property (@(posedge clk) disable iff (rst) $fell(scl_oe) |-> $stable(sda_oe));

    // R8
    stretch_line_chk: assert property (@(posedge clk) disable iff (rst) stretch |-> (!scl_in && !scl_oe));

    // R8
    stretch_nodone_chk: assert property (@(posedge clk) disable iff (rst) stretch |=> !done);

    // R5
    rx_high_chk: assert property (@(posedge clk) disable iff (rst) !$stable(rx_bit) |-> $past(!scl_oe));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl_in),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .rx_bit  (rx_bit),
    .done    (done),
    .stretch (stretch)
);

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;
    import i2c_tm_pkg::*;

    localparam int CW = 16;

    typedef struct {
        int    lat;
        bit    chk_rx;
        bit    rx;
        int    str;
        int    gap;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_period, cfg_low, cfg_cond_setup, cfg_data_setup;
    logic          req_valid = 1'b0;
    logic [2:0]    req_cmd = 3'd0;
    logic          req_bit = 1'b0;
    logic          scl_in, sda_in;
    logic          scl_oe, sda_oe, rx_bit, done, stretch;

    logic hold = 1'b0;
    logic slave_sda = 1'b1;
    bit   slave_a = 1'b1;
    int   stretch_left = 0;
    int   hc = 0;
    int   mid = 0;

    int cyc = 0, t0 = 0, n_chk = 0, n_bad = 0;
    int str_seen = 0, last_change = 0, meas_gap = -1;
    logic prev_sda = 1'b0, prev_scl = 1'b0;
    exp_t q[$];

    assign scl_in = ~scl_oe & ~hold;
    assign sda_in = ~sda_oe & slave_sda;

    i2c_scl_timer #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst),
        .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_cond_setup(cfg_cond_setup), .cfg_data_setup(cfg_data_setup),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bit(req_bit),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_bit(rx_bit),
        .done(done), .stretch(stretch)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // Slave model: stretching and a data flip right after the high-phase midpoint.
    always @(negedge clk) begin
        if (!scl_oe && stretch_left > 0) begin
            hold = 1'b1;
            stretch_left--;
        end else begin
            hold = 1'b0;
        end
        if (scl_oe) begin
            hc = 0;
            slave_sda = slave_a;
        end else if (!hold) begin
            slave_sda = (hc <= mid) ? slave_a : ~slave_a;
            hc++;
        end
    end

    // Monitor: pops the expected item on each done and compares.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (stretch) str_seen++;
            if (sda_oe !== prev_sda) last_change = cyc;
            if (prev_scl && !scl_oe) meas_gap = cyc - last_change;
            prev_sda = sda_oe;
            prev_scl = scl_oe;
            if (done) begin
                if (q.size() == 0) begin
                    chk("R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.req, " latency"}, cyc - t0, e.lat);
                    chk("R8 stretch cycles", str_seen, e.str);
                    if (e.chk_rx) chk("R5 rx_bit", int'(rx_bit), int'(e.rx));
                    if (e.gap >= 0) chk("R4 data setup gap", meas_gap, e.gap);
                end
            end
        end
    end

    task automatic issue(input int cmd, input bit b, input int lat, input bit chk_rx,
                         input bit rx, input int str, input int gap, input string req);
        exp_t e;
        e.lat = lat; e.chk_rx = chk_rx; e.rx = rx; e.str = str; e.gap = gap; e.req = req;
        @(negedge clk);
        q.push_back(e);
        str_seen = 0;
        meas_gap = -1;
        stretch_left = str;
        slave_a = rx;
        mid = (int'(cfg_period) - int'(cfg_low)) / 2;
        req_valid = 1'b1;
        req_cmd = 3'(cmd);
        req_bit = b;
        @(posedge clk);
        #1 t0 = cyc;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int unsigned p;
        p = bit_cycles(16_000_000, 400_000);
        cfg_period = CW'(p);
        cfg_low = CW'(low_cycles(p));
        cfg_cond_setup = CW'(cond_cycles(p));
        cfg_data_setup = CW'(data_cycles(p));   // 40 / 20 / 20 / 2

        repeat (3) @(negedge clk);
        chk("R1 scl_oe in reset", int'(scl_oe), 0);
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 done in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl_oe after reset", int'(scl_oe), 0);

        issue(0, 1'b0, 20, 0, 1'b1, 0, -1, "R2 start");
        wait_idle();
        chk("R2 scl low after start", int'(scl_oe), 1);
        chk("R2 sda low after start", int'(sda_oe), 1);

        issue(3, 1'b1, 40, 0, 1'b1, 0, 2, "R3 write one");
        wait_idle();
        chk("R4 write one releases sda", int'(sda_oe), 0);
        issue(3, 1'b0, 40, 0, 1'b1, 0, 2, "R3 write zero");
        wait_idle();
        chk("R3 scl low after bit", int'(scl_oe), 1);
        issue(4, 1'b0, 40, 1, 1'b1, 0, 2, "R5 read one");
        wait_idle();
        issue(4, 1'b0, 40, 1, 1'b0, 0, -1, "R5 read zero");
        wait_idle();

        issue(3, 1'b0, 45, 0, 1'b1, 5, 2, "R8 stretched write");
        wait_idle();
        issue(4, 1'b0, 43, 1, 1'b1, 3, 2, "R8 stretched read");
        wait_idle();

        // R9: a STOP request in the middle of a write is dropped.
        issue(3, 1'b1, 40, 0, 1'b1, 0, -1, "R9 busy write");
        repeat (5) @(negedge clk);
        req_valid = 1'b1;
        req_cmd = 3'(CMD_STOP);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R9 scl still low after dropped stop", int'(scl_oe), 1);
        chk("R9 sda unchanged after dropped stop", int'(sda_oe), 0);

        // R9: illegal code while idle.
        req_valid = 1'b1;
        req_cmd = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 illegal code scl", int'(scl_oe), 1);
        chk("R9 illegal code sda", int'(sda_oe), 0);

        issue(2, 1'b0, 60, 0, 1'b1, 0, -1, "R7 repeated start");
        wait_idle();
        chk("R7 scl low after rstart", int'(scl_oe), 1);
        chk("R7 sda low after rstart", int'(sda_oe), 1);

        cfg_period = CW'(30);
        cfg_low = CW'(12);
        cfg_data_setup = CW'(4);
        issue(3, 1'b1, 30, 0, 1'b1, 0, 4, "R3 write short period");
        wait_idle();
        issue(4, 1'b0, 30, 1, 1'b0, 0, -1, "R5 read short period");
        wait_idle();
        issue(1, 1'b0, 32, 0, 1'b1, 0, 4, "R6 stop");
        wait_idle();
        chk("R6 scl released after stop", int'(scl_oe), 0);
        chk("R6 sda released after stop", int'(sda_oe), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule